// File: doc/BRIEF.md
# Burst Read Target with Wait States

This block is the responding side of a synchronous external expansion bus, handling read bursts that a bus master starts into the chip. It serves up to eight 32-bit words from a local eight-entry word buffer. That buffer appears here as a static input vector, and how it gets filled is outside this block. When a read starts, the target pulls its active-low wait output low for a configurable number of cycles. It then returns one word per cycle, together with four bits of even byte parity.

During the burst the master drives a 3-bit word address. The target takes that address as the first word index at the start of the access. A master idle cycle is chip select low with the read strobe high. After such a cycle the target takes the bus address again. In every other data cycle the address lines are don't-care, and the target uses its own word pointer, which wraps modulo eight. The master may end the burst in any cycle by raising chip select. A burst also ends by itself after the eighth word, or after one word when the burst flag was low at the start.

Top module: `burst_rd_target`

## Requirements
- R1: After reset, wait_n is 1, and data and parity are all zeros until the first word is transferred.
- R2: A read starts in an idle cycle with cs_n=0, rd_n=0 and wr_n=1. From the next cycle, wait_n is 0 for exactly L cycles, where L is the latency input sampled at the start and a value of 0 counts as 1. It is then 1 again.
- R3: The first transferred word is buffer entry N, where N is the word address sampled in the start cycle. Entry N occupies bits [32N+31:32N] of the buffer input.
- R4: In a transfer cycle that follows another transfer, or follows the first data cycle, the address lines are ignored. The word is the entry after the previous one, modulo 8.
- R5: In an idle cycle (cs_n=0, rd_n=1 during the burst) no word is transferred, and data and parity hold their previous values. The transfer after it uses the bus address, and the pointer continues from that address.
- R6: After the eighth transfer the target is idle. wait_n is 1 in the next cycle and no word is driven, even with the read strobe still low.
- R7: Once wait_n is released, cs_n=1 in any cycle ends the burst. In that cycle wait_n is 1, and data and parity hold.
- R8: Parity bit b is the XOR of data byte b (bits [8b+7:8b]), so each byte plus its parity bit has even weight.
- R9: In a transfer cycle, a data byte whose byte enable be_n[b] is 1 reads as zero.
- R10: When the burst flag is 0 in the start cycle, exactly one word is transferred, and then the target is idle.
- R11: A cycle with wr_n=0 never starts a read. wait_n stays 1 and the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| be_n | input | 4 | Byte enables, active low |
| burst | input | 1 | Burst flag sampled at start (1 = up to eight words) |
| word_addr | input | 3 | Word address bits |
| lat | input | 4 | Wait latency in cycles, static |
| buf_words | input | 256 | Eight buffer words, entry N at [32N+31:32N] |
| wait_n | output | 1 | Wait, active low |
| data | output | 32 | Read data |
| par | output | 4 | Even parity per data byte |

## Verification
Two events can coincide in one cycle: a transfer that must take its index from the bus rather than from the pointer, and the masking of bytes by the byte enables. The pointer wrap and the eighth-word exit can also coincide. Random bursts place idle cycles at random points and change the bus address to random values in every data cycle. They also draw fresh byte enables per transfer and random start addresses near the wrap point. Each word is judged against a bench model, which selects the index as either the pointer or the bus address and then applies the byte mask and parity.

// File: rtl/burst_rd_target.sv
module burst_rd_target #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  parameter int LW    = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int NB   = W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic [NB-1:0]    be_n,
  input  logic             burst,
  input  logic [AW-1:0]    word_addr,
  input  logic [LW-1:0]    lat,
  input  logic [DEPTH*W-1:0] buf_words,
  output logic             wait_n,
  output logic [W-1:0]     data,
  output logic [NB-1:0]    par
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_DATA, S_NOP} st_t;

  st_t st;
  logic [AW-1:0] ptr, cnt, sel;
  logic [LW-1:0] wcnt;
  logic          single;
  logic [W-1:0]  raw, word, hold;
  logic [NB-1:0] wpar, phold;

  wire start  = !cs_n && !rd_n && wr_n;
  wire active = (st == S_DATA) || (st == S_NOP);
  wire xfer   = active && !cs_n && !rd_n;

  assign sel = (st == S_NOP) ? word_addr : ptr;
  assign raw = buf_words[int'(sel)*W +: W];

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign word[b*8 +: 8] = be_n[b] ? 8'h00 : raw[b*8 +: 8];
    assign wpar[b]        = ^word[b*8 +: 8];
  end

  assign wait_n = (st != S_WAIT);
  assign data   = xfer ? word : hold;
  assign par    = xfer ? wpar : phold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ptr    <= '0;
      cnt    <= '0;
      wcnt   <= '0;
      single <= 1'b0;
      hold   <= '0;
      phold  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st     <= S_WAIT;
          ptr    <= word_addr;
          cnt    <= '0;
          wcnt   <= (lat == '0) ? LW'(1) : lat;
          single <= !burst;
        end
        S_WAIT: begin
          if (cs_n)              st <= S_IDLE;
          else if (wcnt <= 1)    st <= S_DATA;
          else                   wcnt <= wcnt - 1'b1;
        end
        default: begin
          if (cs_n)      st <= S_IDLE;
          else if (rd_n) st <= S_NOP;
          else begin
            hold  <= word;
            phold <= wpar;
            ptr   <= sel + 1'b1;
            cnt   <= cnt + 1'b1;
            st    <= (single || cnt == AW'(DEPTH-1)) ? S_IDLE : S_DATA;
          end
        end
      endcase
    end
  end

  p_start_waits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start) |=> !wait_n);

  p_nop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cs_n && rd_n) |-> ($stable(data) && $stable(par)));

  p_eight_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && cnt == AW'(DEPTH-1)) |=> (st == S_IDLE));

  p_cs_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && cs_n) |=> (st == S_IDLE && wait_n));

  p_byte_parity_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> (par[0] == ^data[7:0]));

  p_write_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !wr_n) |=> (st == S_IDLE));

endmodule

// File: tb/burst_rd_target_bench.sv
module burst_rd_target_bench;
  logic clk = 0, rst_n = 0;
  logic cs_n = 1, rd_n = 1, wr_n = 1, burst = 1;
  logic [3:0] be_n = 0, lat = 1;
  logic [2:0] word_addr = 0;
  logic [255:0] buf_words;
  logic wait_n;
  logic [31:0] data;
  logic [3:0] par;
  logic [31:0] mem [8];
  logic [31:0] last_w;
  logic [3:0] last_p;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  burst_rd_target u_burst_rd_target (.clk, .rst_n, .cs_n, .rd_n, .wr_n, .be_n,
    .burst, .word_addr, .lat, .buf_words, .wait_n, .data, .par);

  function automatic logic [31:0] mask_w(input logic [31:0] w, input logic [3:0] be);
    logic [31:0] r = w;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = 8'h00;
    return r;
  endfunction

  function automatic logic [3:0] par_of(input logic [31:0] w);
    logic [3:0] p;
    for (int b = 0; b < 4; b++) p[b] = ^w[b*8 +: 8];
    return p;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input bit c, input bit r, input bit w, input logic [2:0] a, input logic [3:0] be);
    @(negedge clk);
    cs_n = c; rd_n = r; wr_n = w; word_addr = a; be_n = be;
    #2;
  endtask

  task automatic run_burst(input logic [2:0] a0, input logic [3:0] L, input int n,
                           input bit bst, input int nop_pct);
    logic [2:0] ptr, a, idx;
    logic [3:0] be;
    logic [31:0] ew;
    bit pn;
    int k, eff;
    drive(1, 1, 1, 3'($urandom), 0);
    lat = L; burst = bst;
    drive(0, 0, 1, a0, 0);
    chk(wait_n == 1, "R2 start cycle wait_n", wait_n, 1);
    eff = (L == 0) ? 1 : int'(L);
    for (int i = 0; i < eff; i++) begin
      drive(0, 0, 1, 3'($urandom), 0);
      chk(wait_n == 0, "R2 wait held low", wait_n, 0);
    end
    ptr = a0; pn = 0; k = 0;
    while (k < n) begin
      if (int'($urandom_range(99)) < nop_pct) begin
        drive(0, 1, 1, 3'($urandom), 4'($urandom));
        chk(data == last_w && par == last_p, "R5 idle cycle holds", {data, 28'(par)}, {last_w, 28'(last_p)});
        pn = 1;
      end else begin
        a = 3'($urandom); be = ($urandom_range(3) == 0) ? 4'($urandom) : 4'h0;
        drive(0, 0, 1, a, be);
        idx = pn ? a : ptr;
        ew = mask_w(mem[idx], be);
        chk(data == ew, pn ? "R5 bus address after idle" : (k == 0 ? "R3 first word" :
            (be != 0 ? "R9 byte enables" : "R4 pointer word")), data, ew);
        chk(par == par_of(ew), "R8 byte parity", par, par_of(ew));
        chk(wait_n == 1, "R2 wait released in data", wait_n, 1);
        last_w = ew; last_p = par_of(ew);
        ptr = idx + 1'b1; k++; pn = 0;
      end
    end
    if (n == 8 || !bst) begin
      drive(0, 0, 1, 3'($urandom), 0);
      chk(wait_n == 1 && data == last_w, bst ? "R6 idle after eighth" : "R10 single word end",
          {wait_n, data}, {1'b1, last_w});
    end else begin
      drive(1, 0, 1, 3'($urandom), 0);
      chk(wait_n == 1 && data == last_w && par == last_p, "R7 early end holds",
          {wait_n, data}, {1'b1, last_w});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 8; i++) begin
      mem[i] = $urandom;
      buf_words[i*32 +: 32] = mem[i];
    end
    last_w = 0; last_p = 0;
    repeat (3) @(negedge clk);
    #2;
    chk(wait_n == 1 && data == 0 && par == 0, "R1 reset state", {wait_n, data, par}, 37'h1_0000_0000_0);
    rst_n = 1;
    drive(1, 1, 1, 0, 0);
    chk(wait_n == 1 && data == 0, "R1 idle after reset", {wait_n, data}, {1'b1, 32'h0});

    for (int i = 0; i < 4; i++) begin
      drive(0, 0, 0, 3'($urandom), 0);
      chk(wait_n == 1 && data == last_w, "R11 write does not start read", {wait_n, data}, {1'b1, last_w});
    end
    drive(1, 1, 1, 0, 0);
    chk(wait_n == 1, "R11 still idle after writes", wait_n, 1);

    run_burst(3'd6, 4'd0, 8, 1, 0);
    run_burst(3'd7, 4'd15, 8, 1, 0);
    run_burst(3'd2, 4'd3, 1, 0, 0);
    run_burst(3'd5, 4'd2, 3, 1, 30);
    run_burst(3'd0, 4'd1, 8, 1, 40);

    lat = 4'd10;
    drive(1, 1, 1, 0, 0);
    drive(0, 0, 1, 3'd1, 0);
    drive(0, 0, 1, 3'd1, 0);
    chk(wait_n == 0, "R2 wait before abort", wait_n, 0);
    drive(1, 1, 1, 0, 0);
    drive(1, 1, 1, 0, 0);
    chk(wait_n == 1 && data == last_w, "R7 abort during wait", {wait_n, data}, {1'b1, last_w});

    for (int t = 0; t < 300; t++) begin
      int nw;
      bit b;
      b = ($urandom_range(5) != 0);
      nw = b ? int'($urandom_range(1, 8)) : 1;
      run_burst(3'($urandom), 4'($urandom), nw, b, int'($urandom_range(40)));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule